// File: doc/BRIEF.md
# Multipurpose Pin Bank Controller

This block owns a bank of shared pins. Each pin either carries the signal of the peripheral that normally owns it, or acts as a general-purpose input or output under software control. Three registers set this up, one bit per pin in each: a mode register (1 = general-purpose, 0 = normal function), a direction register (1 = output, 0 = input) and a data register. A simple register bus writes and reads them.

The block drives an output-enable and an output value to every pad. It returns synchronized pad levels through the data register, and produces weak pull-up and pull-down select bits for the pad cells. Setting a pin's data bit to 0 and toggling its direction bit gives open-drain behaviour: the pin either drives low or floats.

Two resets reach the block. Power-on reset loads a per-pin default configuration from parameters; by default the upper pins, which serve as high address lines and bus control, come up on their normal function. A watchdog reset clears only the input synchronizer and leaves the configuration and the pad drive as they are.

Top module: `mpio_bank`

## Requirements
- R1: While `por_n` is low at a clock edge, the next cycle shows mode = `DEF_MODE`, direction = `DEF_DIR` and data = 0 on the register read port.
- R2: A write with `reg_we` high at a clock edge updates the addressed register after that edge. The pad drive changes in the same cycle as the register.
- R3: For a pin in general-purpose mode, `pad_oe` equals its direction bit and `pad_out` equals its data bit. `norm_oe` and `norm_out` have no effect on that pin.
- R4: For a pin in normal mode, `pad_oe` and `pad_out` follow `norm_oe` and `norm_out` in the same cycle.
- R5: `norm_in` carries `pad_in` for pins in normal mode and reads 0 for pins in general-purpose mode.
- R6: `pad_pu` is set only for a general-purpose input whose `PULL_UP` bit is set. `pad_pd` is set only for a general-purpose input whose `PULL_DN` bit is set and whose `PULL_UP` bit is clear. Outputs and normal-mode pins get neither.
- R7: With a pin's data bit at 0, writing its direction bit to 1 drives the pad low (`pad_oe`=1, `pad_out`=0). Writing it to 0 releases the pad (`pad_oe`=0).
- R8: Reading the data register returns the latched data bit for output pins. For input pins it returns `pad_in` delayed by two clock edges through the synchronizer.
- R9: While `wdt_rst_n` is low and no write occurs, the mode, direction and data registers and the pad drive keep their values, and the synchronizer reads 0.
- R10: Register addresses are 0 for mode, 1 for direction and 2 for data. Address 3 reads 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, synchronous, active low |
| wdt_rst_n | input | 1 | Watchdog reset, synchronous, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | NPIN | Write data |
| reg_rdata | output | NPIN | Read data for `reg_addr` |
| norm_oe | input | NPIN | Output enable from the normal function |
| norm_out | input | NPIN | Output value from the normal function |
| norm_in | output | NPIN | Pad level passed to the normal function |
| pad_in | input | NPIN | Pad input level |
| pad_oe | output | NPIN | Pad output enable |
| pad_out | output | NPIN | Pad output value |
| pad_pu | output | NPIN | Weak pull-up select |
| pad_pd | output | NPIN | Weak pull-down select |

## Verification
On every cycle, the assertions check the pad mux in both modes, the gating of `norm_in`, the exclusivity and gating of the pull selects, the power-on defaults, and the hold of the configuration during a watchdog reset. Some behaviour only the bench's scenarios can show: the two-edge latency of the input path, the open-drain sequence, the inert reserved address, and read-back across a mix of directions and pad levels.

// File: rtl/mpio_pkg.sv
// Package: shared address map for the multipurpose pin bank.
// Assumes a two-bit register address space.
package mpio_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        MPIO_A_MODE = 2'd0,
        MPIO_A_DIR  = 2'd1,
        MPIO_A_DATA = 2'd2,
        MPIO_A_RSV  = 2'd3
    } mpio_addr_e;
endpackage

// File: rtl/mpio_regs.sv
// Module: configuration register file (mode, direction, data).
// Only the power-on reset initializes it; the watchdog reset never reaches it.
// Writes land on the clock edge that samples we.
module mpio_regs #(
    parameter int          NPIN     = 32,
    parameter logic [NPIN-1:0] DEF_MODE = '0,
    parameter logic [NPIN-1:0] DEF_DIR  = '0
) (
    input  logic                      clk,
    input  logic                      por_n,
    input  logic                      we,
    input  logic [mpio_pkg::ADDR_W-1:0] addr,
    input  logic [NPIN-1:0]           wdata,
    output logic [NPIN-1:0]           mode_q,
    output logic [NPIN-1:0]           dir_q,
    output logic [NPIN-1:0]           data_q
);
    import mpio_pkg::*;

    // Load defaults on power-on reset, otherwise take addressed writes.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            mode_q <= DEF_MODE;
            dir_q  <= DEF_DIR;
            data_q <= '0;
        end else if (we) begin
            case (mpio_addr_e'(addr))
                MPIO_A_MODE: mode_q <= wdata;
                MPIO_A_DIR:  dir_q  <= wdata;
                MPIO_A_DATA: data_q <= wdata;
                default:     ;
            endcase
        end
    end
endmodule

// File: rtl/mpio_sync.sv
// Module: multi-stage input synchronizer for the pad levels.
// Cleared by either reset; output is the last stage.
module mpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stage_q;

    // First stage captures the asynchronous pad level.
    always_ff @(posedge clk) begin
        if (!clr_n) stage_q[0] <= '0;
        else        stage_q[0] <= d;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            // Each further stage re-registers the previous one.
            always_ff @(posedge clk) begin
                if (!clr_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/mpio_pinmux.sv
// Module: per-pin selection between the normal function and the
// general-purpose path, plus pull-select generation. Purely combinational.
module mpio_pinmux #(
    parameter int          NPIN    = 32,
    parameter logic [NPIN-1:0] PULL_UP = '0,
    parameter logic [NPIN-1:0] PULL_DN = '0
) (
    input  logic [NPIN-1:0] mode,
    input  logic [NPIN-1:0] dir,
    input  logic [NPIN-1:0] data,
    input  logic [NPIN-1:0] norm_oe,
    input  logic [NPIN-1:0] norm_out,
    input  logic [NPIN-1:0] pad_in,
    output logic [NPIN-1:0] norm_in,
    output logic [NPIN-1:0] pad_oe,
    output logic [NPIN-1:0] pad_out,
    output logic [NPIN-1:0] pad_pu,
    output logic [NPIN-1:0] pad_pd
);
    generate
        for (genvar i = 0; i < NPIN; i++) begin : g_pin
            // Pick the drive source and pull select for one pin.
            always_comb begin
                if (mode[i]) begin
                    pad_oe[i]  = dir[i];
                    pad_out[i] = data[i];
                    norm_in[i] = 1'b0;
                    pad_pu[i]  = !dir[i] && PULL_UP[i];
                    pad_pd[i]  = !dir[i] && PULL_DN[i] && !PULL_UP[i];
                end else begin
                    pad_oe[i]  = norm_oe[i];
                    pad_out[i] = norm_out[i];
                    norm_in[i] = pad_in[i];
                    pad_pu[i]  = 1'b0;
                    pad_pd[i]  = 1'b0;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/mpio_bank.sv
// Module: top of the multipurpose pin bank. Ties the register file,
// input synchronizer and pin mux together and forms the read port.
// Assumes synchronous active-low resets; watchdog reset clears only the synchronizer.
module mpio_bank #(
    parameter int          NPIN     = 32,
    parameter int          SYNC_STG = 2,
    parameter logic [NPIN-1:0] DEF_MODE = 32'h00FF_FFFF,
    parameter logic [NPIN-1:0] DEF_DIR  = 32'h0000_0000,
    parameter logic [NPIN-1:0] PULL_UP  = 32'h0000_FFFF,
    parameter logic [NPIN-1:0] PULL_DN  = 32'h00FF_0000
) (
    input  logic                        clk,
    input  logic                        por_n,
    input  logic                        wdt_rst_n,
    input  logic                        reg_we,
    input  logic [mpio_pkg::ADDR_W-1:0] reg_addr,
    input  logic [NPIN-1:0]             reg_wdata,
    output logic [NPIN-1:0]             reg_rdata,
    input  logic [NPIN-1:0]             norm_oe,
    input  logic [NPIN-1:0]             norm_out,
    output logic [NPIN-1:0]             norm_in,
    input  logic [NPIN-1:0]             pad_in,
    output logic [NPIN-1:0]             pad_oe,
    output logic [NPIN-1:0]             pad_out,
    output logic [NPIN-1:0]             pad_pu,
    output logic [NPIN-1:0]             pad_pd
);
    import mpio_pkg::*;

    logic [NPIN-1:0] mode_q, dir_q, data_q, pin_sync;
    logic            sync_clr_n;

    assign sync_clr_n = por_n && wdt_rst_n;

    mpio_regs #(.NPIN(NPIN), .DEF_MODE(DEF_MODE), .DEF_DIR(DEF_DIR)) u_regs (
        .clk    (clk),
        .por_n  (por_n),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .mode_q (mode_q),
        .dir_q  (dir_q),
        .data_q (data_q)
    );

    mpio_sync #(.W(NPIN), .STAGES(SYNC_STG)) u_sync (
        .clk   (clk),
        .clr_n (sync_clr_n),
        .d     (pad_in),
        .q     (pin_sync)
    );

    mpio_pinmux #(.NPIN(NPIN), .PULL_UP(PULL_UP), .PULL_DN(PULL_DN)) u_mux (
        .mode     (mode_q),
        .dir      (dir_q),
        .data     (data_q),
        .norm_oe  (norm_oe),
        .norm_out (norm_out),
        .pad_in   (pad_in),
        .norm_in  (norm_in),
        .pad_oe   (pad_oe),
        .pad_out  (pad_out),
        .pad_pu   (pad_pu),
        .pad_pd   (pad_pd)
    );

    // Read port: outputs return the latch, inputs the synchronized level.
    always_comb begin
        case (mpio_addr_e'(reg_addr))
            MPIO_A_MODE: reg_rdata = mode_q;
            MPIO_A_DIR:  reg_rdata = dir_q;
            MPIO_A_DATA: reg_rdata = (dir_q & data_q) | (~dir_q & pin_sync);
            default:     reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mpio_bank_chk.sv
// Module: assertion checker bound into mpio_bank.
// Observes the register outputs and the mux outputs as separate pieces.
module mpio_bank_chk #(
    parameter int          NPIN     = 32,
    parameter logic [NPIN-1:0] DEF_MODE = '0,
    parameter logic [NPIN-1:0] DEF_DIR  = '0
) (
    input logic                        clk,
    input logic                        por_n,
    input logic                        wdt_rst_n,
    input logic                        reg_we,
    input logic [mpio_pkg::ADDR_W-1:0] reg_addr,
    input logic [NPIN-1:0]             reg_wdata,
    input logic [NPIN-1:0]             mode_q,
    input logic [NPIN-1:0]             dir_q,
    input logic [NPIN-1:0]             data_q,
    input logic [NPIN-1:0]             norm_oe,
    input logic [NPIN-1:0]             norm_out,
    input logic [NPIN-1:0]             norm_in,
    input logic [NPIN-1:0]             pad_oe,
    input logic [NPIN-1:0]             pad_out,
    input logic [NPIN-1:0]             pad_pu,
    input logic [NPIN-1:0]             pad_pd
);
    assert_por_default_R1: assert property (@(posedge clk)
        !por_n |=> (mode_q == DEF_MODE && dir_q == DEF_DIR && data_q == '0));

    assert_dir_write_R2: assert property (@(posedge clk) disable iff (!por_n)
        (reg_we && reg_addr == 2'd1) |=> dir_q == $past(reg_wdata));

    assert_pio_drive_R3: assert property (@(posedge clk) disable iff (!por_n)
        (((pad_oe ^ dir_q) | (pad_out ^ data_q)) & mode_q) == '0);

    assert_norm_drive_R4: assert property (@(posedge clk) disable iff (!por_n)
        (((pad_oe ^ norm_oe) | (pad_out ^ norm_out)) & ~mode_q) == '0);

    assert_norm_in_cut_R5: assert property (@(posedge clk) disable iff (!por_n)
        (norm_in & mode_q) == '0);

    assert_pull_gate_R6: assert property (@(posedge clk) disable iff (!por_n)
        ((pad_pu & pad_pd) == '0) && (((pad_pu | pad_pd) & ~(mode_q & ~dir_q)) == '0));

    assert_wdt_hold_R9: assert property (@(posedge clk) disable iff (!por_n)
        (!wdt_rst_n && !reg_we) |=> ($stable(mode_q) && $stable(dir_q) && $stable(data_q)));
endmodule

bind mpio_bank mpio_bank_chk #(.NPIN(NPIN), .DEF_MODE(DEF_MODE), .DEF_DIR(DEF_DIR)) u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .wdt_rst_n (wdt_rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .mode_q    (mode_q),
    .dir_q     (dir_q),
    .data_q    (data_q),
    .norm_oe   (norm_oe),
    .norm_out  (norm_out),
    .norm_in   (norm_in),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .pad_pu    (pad_pu),
    .pad_pd    (pad_pd)
);

// File: tb/mpio_bank_tb.sv
// Bench: behavioural reference model of the pin bank, compared at every negedge.
module mpio_bank_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N = 32;
    localparam logic [N-1:0] D_MODE = 32'h00FF_FFFF;
    localparam logic [N-1:0] D_DIR  = 32'h0000_0000;
    localparam logic [N-1:0] P_UP   = 32'h0000_FFFF;
    localparam logic [N-1:0] P_DN   = 32'h00FF_0000;

    logic clk = 1'b0;
    logic por_n, wdt_rst_n, reg_we;
    logic [1:0] reg_addr;
    logic [N-1:0] reg_wdata, reg_rdata, norm_oe, norm_out, norm_in;
    logic [N-1:0] pad_in, pad_oe, pad_out, pad_pu, pad_pd;

    // reference state
    logic [N-1:0] m_mode, m_dir, m_data, m_s1, m_s2;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mpio_bank u_dut (
        .clk(clk), .por_n(por_n), .wdt_rst_n(wdt_rst_n), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .norm_oe(norm_oe), .norm_out(norm_out), .norm_in(norm_in),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
        .pad_pu(pad_pu), .pad_pd(pad_pd)
    );

    task automatic chk(input string req, input string what,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [N-1:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0: return m_mode;
            2'd1: return m_dir;
            2'd2: return (m_dir & m_data) | (~m_dir & m_s2);
            default: return '0;
        endcase
    endfunction

    // Model update for one rising edge, using the inputs held since the last negedge.
    task automatic model_edge();
        if (!por_n) begin
            m_mode = D_MODE; m_dir = D_DIR; m_data = '0; m_s1 = '0; m_s2 = '0;
        end else begin
            if (!wdt_rst_n) begin m_s1 = '0; m_s2 = '0; end
            else begin m_s2 = m_s1; m_s1 = pad_in; end
            if (reg_we) begin
                if (reg_addr == 2'd0) m_mode = reg_wdata;
                else if (reg_addr == 2'd1) m_dir = reg_wdata;
                else if (reg_addr == 2'd2) m_data = reg_wdata;
            end
        end
    endtask

    task automatic compare_all();
        chk("R3", "pad_oe",  pad_oe,  (m_mode & m_dir)  | (~m_mode & norm_oe));
        chk("R4", "pad_out", pad_out, (m_mode & m_data) | (~m_mode & norm_out));
        chk("R5", "norm_in", norm_in, pad_in & ~m_mode);
        chk("R6", "pad_pu",  pad_pu,  m_mode & ~m_dir & P_UP);
        chk("R6", "pad_pd",  pad_pd,  m_mode & ~m_dir & P_DN & ~P_UP);
        chk("R8", "rdata",   reg_rdata, exp_rd(reg_addr));
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
        reg_we = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        step();
    endtask

    initial begin
        por_n = 0; wdt_rst_n = 1; reg_we = 0; reg_addr = 0; reg_wdata = '0;
        norm_oe = '0; norm_out = '0; pad_in = '0;
        m_mode = 'x; m_dir = 'x; m_data = 'x; m_s1 = 'x; m_s2 = 'x;
        step(); step();
        // R1: reset defaults read back
        reg_addr = 2'd0; #1; chk("R1", "mode default", reg_rdata, D_MODE);
        reg_addr = 2'd1; #1; chk("R1", "dir default", reg_rdata, D_DIR);
        por_n = 1;
        step();

        // R2: writes visible after the edge
        wr(2'd1, 32'h0000_00F0);
        reg_addr = 2'd1; #1; chk("R2", "dir write", reg_rdata, 32'h0000_00F0);
        wr(2'd2, 32'h0000_00A5);
        chk("R2", "pad_out after data write", pad_out & 32'hF0, 32'hA0);

        // R4 / R5: normal-function pins under varying patterns
        for (int k = 0; k < 40; k++) begin
            norm_oe = $urandom; norm_out = $urandom; pad_in = $urandom;
            reg_addr = 2'(k % 4);
            step();
        end
        chk("R4", "upper pins follow norm_out", pad_out & 32'hFF00_0000, norm_out & 32'hFF00_0000);

        // R10: reserved address write is inert and reads zero
        wr(2'd3, 32'hFFFF_FFFF);
        reg_addr = 2'd3; #1; chk("R10", "reserved read", reg_rdata, '0);
        reg_addr = 2'd0; #1; chk("R10", "mode unchanged", reg_rdata, D_MODE);

        // R7: open drain on pin 3 with data held at 0
        wr(2'd2, 32'h0000_0000);
        wr(2'd1, 32'h0000_0008);
        chk("R7", "od drive low oe", pad_oe & 32'h8, 32'h8);
        chk("R7", "od drive low val", pad_out & 32'h8, 32'h0);
        wr(2'd1, 32'h0000_0000);
        chk("R7", "od release", pad_oe & 32'h8, 32'h0);

        // R8: synchronizer latency on input pins
        pad_in = 32'h0000_5555; reg_addr = 2'd2;
        step();
        chk("R8", "one edge not yet", reg_rdata === 32'h0000_5555 ? 32'h1 : 32'h0, 32'h0);
        step();
        chk("R8", "two edges visible", reg_rdata & 32'h00FF_FFFF, 32'h0000_5555);

        // R9: watchdog reset holds configuration and pad drive
        wr(2'd0, 32'hFFFF_FFFF);
        wr(2'd1, 32'hFFFF_0000);
        wr(2'd2, 32'h1234_5678);
        wdt_rst_n = 0;
        for (int k = 0; k < 5; k++) begin
            norm_oe = $urandom; pad_in = $urandom; reg_addr = 2'(k % 3);
            step();
        end
        chk("R9", "pad_oe held", pad_oe, 32'hFFFF_0000);
        chk("R9", "pad_out held", pad_out, 32'h1234_5678);
        reg_addr = 2'd2; #1; chk("R9", "sync cleared", reg_rdata, 32'h1234_0000);
        wdt_rst_n = 1;

        // R3: general-purpose pins ignore the normal function
        for (int k = 0; k < 30; k++) begin
            norm_oe = $urandom; norm_out = $urandom; pad_in = $urandom;
            if (k % 7 == 0) begin
                reg_we = 1'b1; reg_addr = 2'(k % 3); reg_wdata = $urandom;
            end else reg_addr = 2'(k % 4);
            step();
        end

        // R1: power-on reset again restores defaults
        por_n = 0; step(); por_n = 1;
        reg_addr = 2'd0; #1; chk("R1", "mode after second por", reg_rdata, D_MODE);
        step();

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule